// File: doc/BRIEF.md
# Learned-Address Table Command Engine

This block holds a small table of learned station addresses for an Ethernet switch. Software reaches it through five 16-bit registers. It places a 48-bit station address in three key registers and an entry word in a data register. It then writes an operation register with its top bit set. The engine runs the chosen command over the 16-entry table, one entry per clock, and clears the top bit once the command is done.

Each table entry holds a 6-bit database tag, the 48-bit address, a 4-bit entry state (0 means empty), a trunk flag and a 5-bit port vector. A load either inserts or overwrites an entry, or removes it. A get-next command walks a database in ascending address order. Flush and move share one opcode family and differ only in the state nibble of the data register. An empty state flushes the entries. An all-ones state moves ports from a from-mask to a to-mask. A state of 0xE marks an entry as static, and the non-static variants leave such entries alone.

Top module: `mat_engine`

## Requirements
- R1: A write of the operation register (address 0) with bit 15 set, while idle, starts a command. Bit 15 of that register then reads 1 for exactly ENTRIES+1 (17) clocks after the write edge, and then reads 0.
- R2: Register addresses are: 0 operation, 1 data, 2/3/4 key. Key register 2 carries address bytes 0 and 1, register 3 bytes 2 and 3, register 4 bytes 4 and 5, with the lower-numbered byte in bits 15:8. Byte 0 is the most significant byte when addresses are compared. The data word carries the state in bits 3:0, the port vector in bits 8:4 and the trunk flag in bit 15. Written values read back unchanged, and all registers read 0 after reset.
- R3: The operation register carries the opcode in bits 14:12 (1 flush-all every database, 2 flush-non-static every database, 3 load, 4 get-next, 5 flush-all one database, 6 flush-non-static one database). Database bits 3:0 sit in bits 3:0 and database bits 5:4 sit in bits 9:8. Both read back, and a write with bit 15 clear stores the fields without starting anything.
- R4: A load with a non-zero state writes the key, state, trunk and port vector under the given database. An existing entry with the same database and key is overwritten, even when the table is full.
- R5: A load with state 0 removes the matching entry. A load of a new key into a table whose 16 entries are all valid is dropped.
- R6: Get-next finds the valid entry of the selected database with the smallest address greater than the key registers. It writes that entry's address into the key registers and its data word into the data register, with all bits other than 15, 8:4 and 3:0 cleared.
- R7: When no such entry exists, get-next sets the key registers to all ones and the data register to 0.
- R8: A flush with data state 0 removes every valid entry in scope: all databases for opcodes 1 and 2, only the given database for opcodes 5 and 6.
- R9: Opcodes 2 and 6 leave entries whose state is 0xE untouched. Opcodes 1 and 5 also remove or move those entries.
- R10: With data state 0xF, a flush opcode acts as a move. The from-mask is in data bits 8:4 and the to-mask in bits 13:9. Each in-scope entry that shares a port with the from-mask gets port vector (pv & ~from) | to. Any other non-zero data state makes a flush opcode change nothing.
- R11: While a command runs, all register writes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address for reads and writes |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data, combinational from reg_addr |

## Verification
Get-next walks are run after each kind of change: after loads in two databases with keys stored out of order, after an overwrite, after a purge, after each flush variant and after moves. The walks show whether ordering, database isolation and removal are right at the same time. The flush tests mix static and dynamic entries across two databases, so the walk results separate the four scope variants. Moves use entries that do and do not touch the from-mask, plus a state that is neither flush nor move. A full table checks that a new key is dropped while an existing key can still be overwritten. A command with writes injected during its run shows whether any register is disturbed.

// File: rtl/mat_pkg.sv
// Shared constants and encodings for the learned-address table engine.
// Assumes a 16-bit register interface and a 6-bit database tag.
package mat_pkg;
    localparam int DB_W  = 6;
    localparam int KEY_W = 48;
    localparam int ST_W  = 4;

    localparam logic [ST_W-1:0] ST_EMPTY  = 4'h0;
    localparam logic [ST_W-1:0] ST_STATIC = 4'hE;
    localparam logic [ST_W-1:0] ST_MOVE   = 4'hF;

    typedef enum logic [2:0] {
        OPC_NOP          = 3'd0,
        OPC_FLUSH_ALL    = 3'd1,
        OPC_FLUSH_DYN    = 3'd2,
        OPC_LOAD         = 3'd3,
        OPC_NEXT         = 3'd4,
        OPC_FLUSH_ALL_DB = 3'd5,
        OPC_FLUSH_DYN_DB = 3'd6,
        OPC_RSVD         = 3'd7
    } opc_e;

    typedef enum logic [2:0] {
        RA_OP    = 3'd0,
        RA_DATA  = 3'd1,
        RA_KEY01 = 3'd2,
        RA_KEY23 = 3'd3,
        RA_KEY45 = 3'd4
    } rsel_e;

    typedef enum logic [1:0] {
        ENG_IDLE = 2'd0,
        ENG_SCAN = 2'd1,
        ENG_FIN  = 2'd2
    } eng_e;
endpackage

// File: rtl/mat_table.sv
// Entry storage: ENTRIES records of {database, key, state, trunk, port vector}.
// One combinational read port by index, one synchronous write port.
// Assumes the caller never writes and reads conflicting data in one cycle.
module mat_table
    import mat_pkg::*;
#(
    parameter int ENTRIES = 16,
    parameter int PV_W    = 5
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [$clog2(ENTRIES)-1:0] rd_idx,
    output logic [DB_W-1:0]            rd_db,
    output logic [KEY_W-1:0]           rd_mac,
    output logic [ST_W-1:0]            rd_state,
    output logic                       rd_trunk,
    output logic [PV_W-1:0]            rd_pv,
    input  logic                       wr_en,
    input  logic [$clog2(ENTRIES)-1:0] wr_idx,
    input  logic [DB_W-1:0]            wr_db,
    input  logic [KEY_W-1:0]           wr_mac,
    input  logic [ST_W-1:0]            wr_state,
    input  logic                       wr_trunk,
    input  logic [PV_W-1:0]            wr_pv
);
    localparam int IDX_W = $clog2(ENTRIES);

    logic [DB_W-1:0]  db_q    [ENTRIES];
    logic [KEY_W-1:0] mac_q   [ENTRIES];
    logic [ST_W-1:0]  state_q [ENTRIES];
    logic             trunk_q [ENTRIES];
    logic [PV_W-1:0]  pv_q    [ENTRIES];

    for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
        // Per-entry record: cleared by reset, replaced when its index is written.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                db_q[g]    <= '0;
                mac_q[g]   <= '0;
                state_q[g] <= ST_EMPTY;
                trunk_q[g] <= 1'b0;
                pv_q[g]    <= '0;
            end else if (wr_en && (wr_idx == IDX_W'(g))) begin
                db_q[g]    <= wr_db;
                mac_q[g]   <= wr_mac;
                state_q[g] <= wr_state;
                trunk_q[g] <= wr_trunk;
                pv_q[g]    <= wr_pv;
            end
        end
    end

    // Read port: selected record by index.
    always_comb begin
        rd_db    = db_q[rd_idx];
        rd_mac   = mac_q[rd_idx];
        rd_state = state_q[rd_idx];
        rd_trunk = trunk_q[rd_idx];
        rd_pv    = pv_q[rd_idx];
    end
endmodule

// File: rtl/mat_eval.sv
// Per-entry command evaluation, purely combinational.
// Decides whether the scanned entry matches a load key, is a get-next candidate,
// or falls in a flush/move scope, and computes the rewritten state and vector.
// Assumes the entry is valid exactly when its state is non-zero.
module mat_eval
    import mat_pkg::*;
#(
    parameter int PV_W = 5
) (
    input  opc_e             opc,
    input  logic [DB_W-1:0]  cmd_db,
    input  logic [KEY_W-1:0] cmd_key,
    input  logic [ST_W-1:0]  cmd_state,
    input  logic [PV_W-1:0]  cmd_from,
    input  logic [PV_W-1:0]  cmd_to,
    input  logic [DB_W-1:0]  ent_db,
    input  logic [KEY_W-1:0] ent_mac,
    input  logic [ST_W-1:0]  ent_state,
    input  logic [PV_W-1:0]  ent_pv,
    output logic             key_hit,
    output logic             key_gt,
    output logic             fm_sel,
    output logic [ST_W-1:0]  fm_state,
    output logic [PV_W-1:0]  fm_pv
);
    logic live;
    logic db_eq;
    logic is_fm;
    logic any_db;
    logic dyn_only;
    logic in_scope;

    // Key comparisons used by load and get-next.
    always_comb begin
        live    = (ent_state != ST_EMPTY);
        db_eq   = (ent_db == cmd_db);
        key_hit = live && db_eq && (ent_mac == cmd_key);
        key_gt  = live && db_eq && (ent_mac > cmd_key);
    end

    // Flush/move scope decode from the opcode.
    always_comb begin
        is_fm    = 1'b1;
        any_db   = 1'b0;
        dyn_only = 1'b0;
        case (opc)
            OPC_FLUSH_ALL:    any_db = 1'b1;
            OPC_FLUSH_DYN:    begin any_db = 1'b1; dyn_only = 1'b1; end
            OPC_FLUSH_ALL_DB: any_db = 1'b0;
            OPC_FLUSH_DYN_DB: dyn_only = 1'b1;
            default:          is_fm = 1'b0;
        endcase
        in_scope = is_fm && live && (any_db || db_eq)
                   && !(dyn_only && (ent_state == ST_STATIC));
    end

    // Action on a selected entry: clear it, or move its ports.
    always_comb begin
        fm_state = ent_state;
        fm_pv    = ent_pv;
        fm_sel   = 1'b0;
        if (cmd_state == ST_EMPTY) begin
            fm_sel   = in_scope;
            fm_state = ST_EMPTY;
        end else if (cmd_state == ST_MOVE) begin
            fm_sel = in_scope && ((ent_pv & cmd_from) != '0);
            fm_pv  = (ent_pv & ~cmd_from) | cmd_to;
        end
    end
endmodule

// File: rtl/mat_engine.sv
// Learned-address table command engine: register file, command sequencer and
// entry table. A command scans every entry, one per clock, and then spends one
// finishing cycle that commits a load or writes back a get-next result.
// Assumes 4 + 2*PV_W <= 15 so the move masks fit below the trunk bit.
module mat_engine
    import mat_pkg::*;
#(
    parameter int ENTRIES = 16,
    parameter int PV_W    = 5
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic [2:0]  reg_addr,
    input  logic [15:0] reg_wdata,
    output logic [15:0] reg_rdata
);
    localparam int IDX_W = $clog2(ENTRIES);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ENTRIES - 1);
    localparam int PAD_W = 16 - 1 - PV_W - ST_W;

    eng_e              eng_q;
    logic [IDX_W-1:0]  idx_q;
    opc_e              opc_q;
    logic [DB_W-1:0]   db_q;
    logic [15:0]       data_q;
    logic [KEY_W-1:0]  key_q;
    logic              hit_q;
    logic [IDX_W-1:0]  hit_idx_q;
    logic              free_q;
    logic [IDX_W-1:0]  free_idx_q;
    logic              nx_q;
    logic [KEY_W-1:0]  nx_mac_q;
    logic [15:0]       nx_data_q;

    logic              wr_ok;
    logic              start;

    logic [DB_W-1:0]   rd_db;
    logic [KEY_W-1:0]  rd_mac;
    logic [ST_W-1:0]   rd_state;
    logic              rd_trunk;
    logic [PV_W-1:0]   rd_pv;

    logic              key_hit;
    logic              key_gt;
    logic              fm_sel;
    logic [ST_W-1:0]   fm_state;
    logic [PV_W-1:0]   fm_pv;

    logic              tbl_we;
    logic [IDX_W-1:0]  tbl_widx;
    logic [DB_W-1:0]   tbl_db;
    logic [KEY_W-1:0]  tbl_mac;
    logic [ST_W-1:0]   tbl_state;
    logic              tbl_trunk;
    logic [PV_W-1:0]   tbl_pv;

    // Accept register writes only while idle; bit 15 of the op word starts a command.
    always_comb begin
        wr_ok = reg_wr && (eng_q == ENG_IDLE);
        start = wr_ok && (reg_addr == RA_OP) && reg_wdata[15];
    end

    mat_table #(.ENTRIES(ENTRIES), .PV_W(PV_W)) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_idx   (idx_q),
        .rd_db    (rd_db),
        .rd_mac   (rd_mac),
        .rd_state (rd_state),
        .rd_trunk (rd_trunk),
        .rd_pv    (rd_pv),
        .wr_en    (tbl_we),
        .wr_idx   (tbl_widx),
        .wr_db    (tbl_db),
        .wr_mac   (tbl_mac),
        .wr_state (tbl_state),
        .wr_trunk (tbl_trunk),
        .wr_pv    (tbl_pv)
    );

    mat_eval #(.PV_W(PV_W)) u_eval (
        .opc       (opc_q),
        .cmd_db    (db_q),
        .cmd_key   (key_q),
        .cmd_state (data_q[ST_W-1:0]),
        .cmd_from  (data_q[ST_W +: PV_W]),
        .cmd_to    (data_q[ST_W+PV_W +: PV_W]),
        .ent_db    (rd_db),
        .ent_mac   (rd_mac),
        .ent_state (rd_state),
        .ent_pv    (rd_pv),
        .key_hit   (key_hit),
        .key_gt    (key_gt),
        .fm_sel    (fm_sel),
        .fm_state  (fm_state),
        .fm_pv     (fm_pv)
    );

    // Register file: software writes when idle, get-next write-back when finishing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            opc_q  <= OPC_NOP;
            db_q   <= '0;
            data_q <= '0;
            key_q  <= '0;
        end else begin
            if (wr_ok) begin
                case (reg_addr)
                    RA_OP: begin
                        opc_q <= opc_e'(reg_wdata[14:12]);
                        db_q  <= {reg_wdata[9:8], reg_wdata[3:0]};
                    end
                    RA_DATA:  data_q        <= reg_wdata;
                    RA_KEY01: key_q[47:32]  <= reg_wdata;
                    RA_KEY23: key_q[31:16]  <= reg_wdata;
                    RA_KEY45: key_q[15:0]   <= reg_wdata;
                    default: ;
                endcase
            end
            if ((eng_q == ENG_FIN) && (opc_q == OPC_NEXT)) begin
                key_q  <= nx_q ? nx_mac_q  : '1;
                data_q <= nx_q ? nx_data_q : '0;
            end
        end
    end

    // Sequencer: idle, scan every entry in index order, then one finishing cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            eng_q <= ENG_IDLE;
            idx_q <= '0;
        end else begin
            case (eng_q)
                ENG_IDLE: if (start) begin
                    eng_q <= ENG_SCAN;
                    idx_q <= '0;
                end
                ENG_SCAN: begin
                    if (idx_q == LAST_IDX) eng_q <= ENG_FIN;
                    idx_q <= idx_q + 1'b1;
                end
                default: eng_q <= ENG_IDLE;
            endcase
        end
    end

    // Scan bookkeeping: load hit, first free slot, best get-next candidate.
    always_ff @(posedge clk) begin
        if (!rst_n || start) begin
            hit_q      <= 1'b0;
            hit_idx_q  <= '0;
            free_q     <= 1'b0;
            free_idx_q <= '0;
            nx_q       <= 1'b0;
            nx_mac_q   <= '0;
            nx_data_q  <= '0;
        end else if (eng_q == ENG_SCAN) begin
            if (key_hit && !hit_q) begin
                hit_q     <= 1'b1;
                hit_idx_q <= idx_q;
            end
            if ((rd_state == ST_EMPTY) && !free_q) begin
                free_q     <= 1'b1;
                free_idx_q <= idx_q;
            end
            if (key_gt && (!nx_q || (rd_mac < nx_mac_q))) begin
                nx_q      <= 1'b1;
                nx_mac_q  <= rd_mac;
                nx_data_q <= {rd_trunk, {PAD_W{1'b0}}, rd_pv, rd_state};
            end
        end
    end

    // Table write port: flush/move rewrites during scan, load commit when finishing.
    always_comb begin
        tbl_we    = 1'b0;
        tbl_widx  = idx_q;
        tbl_db    = rd_db;
        tbl_mac   = rd_mac;
        tbl_state = fm_state;
        tbl_trunk = rd_trunk;
        tbl_pv    = fm_pv;
        if ((eng_q == ENG_SCAN) && fm_sel) begin
            tbl_we = 1'b1;
        end else if ((eng_q == ENG_FIN) && (opc_q == OPC_LOAD)
                     && (hit_q || (free_q && (data_q[ST_W-1:0] != ST_EMPTY)))) begin
            tbl_we    = 1'b1;
            tbl_widx  = hit_q ? hit_idx_q : free_idx_q;
            tbl_db    = db_q;
            tbl_mac   = key_q;
            tbl_state = data_q[ST_W-1:0];
            tbl_trunk = data_q[15];
            tbl_pv    = data_q[ST_W +: PV_W];
        end
    end

    // Read mux: busy flag, opcode and split database number in the op word.
    always_comb begin
        case (reg_addr)
            RA_OP:    reg_rdata = {(eng_q != ENG_IDLE), opc_q, 2'b00, db_q[5:4], 4'b0000, db_q[3:0]};
            RA_DATA:  reg_rdata = data_q;
            RA_KEY01: reg_rdata = key_q[47:32];
            RA_KEY23: reg_rdata = key_q[31:16];
            RA_KEY45: reg_rdata = key_q[15:0];
            default:  reg_rdata = '0;
        endcase
    end

    // R1: an accepted start enters the scan at entry 0.
    p_start_scan_r1: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (eng_q == ENG_SCAN) && (idx_q == '0));

    // R1: the finishing cycle is followed by idle.
    p_fin_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_q == ENG_FIN) |=> (eng_q == ENG_IDLE));

    // R11: writes during a command leave the command fields alone.
    p_busy_ignore_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ((eng_q != ENG_IDLE) && reg_wr) |=> ($stable(opc_q) && $stable(db_q)));

    // R11: writes during the scan leave the data and key registers alone.
    p_busy_keep_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ((eng_q == ENG_SCAN) && reg_wr) |=> ($stable(data_q) && $stable(key_q)));

    // R7: a get-next with no candidate leaves the end marker.
    p_end_marker_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((eng_q == ENG_FIN) && (opc_q == OPC_NEXT) && !nx_q) |=> ((key_q == '1) && (data_q == '0)));

    // R9: non-static flush never writes a static entry.
    p_static_kept_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ((eng_q == ENG_SCAN) && ((opc_q == OPC_FLUSH_DYN) || (opc_q == OPC_FLUSH_DYN_DB))
         && (rd_state == ST_STATIC)) |-> !tbl_we);

    // R4: table writes in the finishing cycle come only from loads.
    p_fin_write_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((eng_q == ENG_FIN) && tbl_we) |-> (opc_q == OPC_LOAD));
endmodule

// File: tb/tb_mat_engine.sv
`timescale 1ns/1ps
module tb_mat_engine;
    localparam int N = 16;
    localparam int BUSY_CYC = N + 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic [15:0] reg_wdata = 16'h0;
    logic [15:0] reg_rdata;

    int n_tests = 0;
    int n_fail  = 0;

    typedef struct {
        logic [5:0]  db;
        logic [47:0] mac;
        logic [3:0]  st;
        logic        tr;
        logic [4:0]  pv;
    } ent_t;

    ent_t        tbl[$];
    logic [15:0] m_data = 16'h0;
    logic [47:0] m_mac  = 48'h0;
    logic [2:0]  m_opc  = 3'd0;
    logic [5:0]  m_db   = 6'd0;

    mat_engine #(.ENTRIES(N), .PV_W(5)) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata)
    );

    always #2.5 clk = ~clk;

    task automatic check(input string req, input string what, input logic [47:0] act, input logic [47:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] v);
        @(negedge clk);
        reg_wr = 1'b0;
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic set_key(input logic [47:0] k);
        wr(3'd2, k[47:32]); wr(3'd3, k[31:16]); wr(3'd4, k[15:0]);
        m_mac = k;
    endtask

    task automatic set_data(input logic [15:0] d);
        wr(3'd1, d);
        m_data = d;
    endtask

    function automatic logic [15:0] mkd(input logic tr, input logic [4:0] pv, input logic [3:0] st);
        return {tr, 6'b0, pv, st};
    endfunction

    // Compare all five registers with the reference model.
    task automatic check_regs(input string req);
        logic [15:0] v;
        rd(3'd0, v); check(req, "op reg", v, {1'b0, m_opc, 2'b00, m_db[5:4], 4'b0000, m_db[3:0]});
        rd(3'd1, v); check(req, "data reg", v, m_data);
        rd(3'd2, v); check(req, "key01", v, m_mac[47:32]);
        rd(3'd3, v); check(req, "key23", v, m_mac[31:16]);
        rd(3'd4, v); check(req, "key45", v, m_mac[15:0]);
    endtask

    // Reference behaviour of one command.
    task automatic model_cmd(input logic [2:0] opc, input logic [5:0] db);
        logic [3:0] st;
        logic [4:0] from;
        logic [4:0] to;
        int k;
        bit any_db;
        bit dyn;
        st = m_data[3:0]; from = m_data[8:4]; to = m_data[13:9];
        if (opc == 3'd3) begin
            k = -1;
            for (int i = 0; i < tbl.size(); i++)
                if (tbl[i].db == db && tbl[i].mac == m_mac) k = i;
            if (k >= 0) begin
                if (st == 4'h0) tbl.delete(k);
                else begin tbl[k].st = st; tbl[k].tr = m_data[15]; tbl[k].pv = m_data[8:4]; end
            end else if (st != 4'h0 && tbl.size() < N) begin
                ent_t e;
                e.db = db; e.mac = m_mac; e.st = st; e.tr = m_data[15]; e.pv = m_data[8:4];
                tbl.push_back(e);
            end
        end else if (opc == 3'd4) begin
            k = -1;
            for (int i = 0; i < tbl.size(); i++)
                if (tbl[i].db == db && tbl[i].mac > m_mac && (k < 0 || tbl[i].mac < tbl[k].mac)) k = i;
            if (k >= 0) begin
                m_mac = tbl[k].mac;
                m_data = mkd(tbl[k].tr, tbl[k].pv, tbl[k].st);
            end else begin
                m_mac = '1;
                m_data = 16'h0;
            end
        end else if (opc == 3'd1 || opc == 3'd2 || opc == 3'd5 || opc == 3'd6) begin
            any_db = (opc == 3'd1 || opc == 3'd2);
            dyn = (opc == 3'd2 || opc == 3'd6);
            for (int i = tbl.size() - 1; i >= 0; i--) begin
                if (!any_db && tbl[i].db != db) continue;
                if (dyn && tbl[i].st == 4'hE) continue;
                if (st == 4'h0) tbl.delete(i);
                else if (st == 4'hF && (tbl[i].pv & from) != 5'd0)
                    tbl[i].pv = (tbl[i].pv & ~from) | to;
            end
        end
    endtask

    // Issue a command, check the busy window every clock, then check all registers.
    task automatic cmd(input logic [2:0] opc, input logic [5:0] db, input bit inject, input string req);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 3'd0;
        reg_wdata = {1'b1, opc, 2'b00, db[5:4], 4'b0000, db[3:0]};
        @(negedge clk);
        reg_wr = 1'b0;
        m_opc = opc; m_db = db;
        for (int c = 0; c < BUSY_CYC; c++) begin
            if (c > 0) @(negedge clk);
            if (inject && c == 4) begin
                reg_wr = 1'b1; reg_addr = 3'd1; reg_wdata = 16'hBEEF;
            end else if (inject && c == 5) begin
                reg_wr = 1'b1; reg_addr = 3'd0; reg_wdata = 16'hF03F;
            end else if (inject && c == 6) begin
                reg_wr = 1'b1; reg_addr = 3'd2; reg_wdata = 16'h1111;
            end else begin
                reg_wr = 1'b0; reg_addr = 3'd0;
                #1 check("R1", "busy during command", reg_rdata[15], 1'b1);
            end
        end
        @(negedge clk);
        reg_wr = 1'b0; reg_addr = 3'd0;
        #1 check("R1", "busy after command", reg_rdata[15], 1'b0);
        model_cmd(opc, db);
        check_regs(req);
    endtask

    task automatic load(input logic [5:0] db, input logic [47:0] mac, input logic [15:0] d, input string req);
        set_key(mac);
        set_data(d);
        cmd(3'd3, db, 1'b0, req);
    endtask

    // Walk one database from key 0 until the end marker.
    task automatic walk(input logic [5:0] db, input string req);
        logic [15:0] v;
        set_key(48'h0);
        for (int s = 0; s < N + 2; s++) begin
            cmd(3'd4, db, 1'b0, req);
            if (m_data[3:0] == 4'h0) break;
        end
        rd(3'd2, v); check("R7", "end marker key01", v, 16'hFFFF);
        rd(3'd1, v); check("R7", "end marker data", v, 16'h0);
    endtask

    initial begin
        #1000000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [15:0] v;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        check_regs("R2");

        // R3: op fields without the start bit
        wr(3'd0, 16'h420B);
        m_opc = 3'd4; m_db = 6'h2B;
        check_regs("R3");

        // R2: register readback and byte order
        set_data(16'hA5C3);
        set_key(48'h0102_0304_0506);
        rd(3'd2, v); check("R2", "byte0 in upper half", v, 16'h0102);
        check_regs("R2");

        // R4: loads out of order in two databases
        load(6'd5, 48'h00AA_0000_0030, mkd(1'b0, 5'h03, 4'h7), "R4");
        load(6'd5, 48'h00AA_0000_0010, mkd(1'b1, 5'h01, 4'h7), "R4");
        load(6'd5, 48'h00AA_0000_0020, mkd(1'b0, 5'h04, 4'h2), "R4");
        load(6'd9, 48'h00AA_0000_0015, mkd(1'b0, 5'h08, 4'h7), "R4");
        load(6'd37, 48'h00AA_0000_0025, mkd(1'b0, 5'h10, 4'h7), "R4");
        walk(6'd5, "R6");
        walk(6'd9, "R6");
        walk(6'd37, "R6");

        // R4: overwrite
        load(6'd5, 48'h00AA_0000_0020, mkd(1'b1, 5'h1F, 4'h3), "R4");
        walk(6'd5, "R6");

        // R5: purge
        load(6'd5, 48'h00AA_0000_0010, 16'h0000, "R5");
        walk(6'd5, "R5");

        // R9: non-static flush of one database spares static entries
        load(6'd5, 48'h00AA_0000_0040, mkd(1'b0, 5'h02, 4'hE), "R9");
        load(6'd9, 48'h00AA_0000_0041, mkd(1'b0, 5'h01, 4'hE), "R9");
        set_data(16'h0000);
        cmd(3'd6, 6'd5, 1'b0, "R9");
        walk(6'd5, "R9");
        walk(6'd9, "R9");

        // R10: move in database 9, from port 0 to port 4
        load(6'd9, 48'h00AA_0000_0050, mkd(1'b0, 5'h03, 4'h7), "R10");
        load(6'd9, 48'h00AA_0000_0060, mkd(1'b0, 5'h04, 4'h7), "R10");
        set_data({2'b00, 5'h10, 5'h01, 4'hF});
        cmd(3'd5, 6'd9, 1'b0, "R10");
        walk(6'd9, "R10");
        // R10: a state that is neither flush nor move changes nothing
        set_data({2'b00, 5'h01, 5'h1F, 4'h3});
        cmd(3'd1, 6'd0, 1'b0, "R10");
        walk(6'd9, "R10");
        // R10: non-static move over every database skips the static entry
        set_data({2'b00, 5'h02, 5'h01, 4'hF});
        cmd(3'd2, 6'd0, 1'b0, "R10");
        walk(6'd9, "R10");

        // R11: writes during a command are ignored
        set_key(48'h0);
        set_data(16'h0000);
        cmd(3'd4, 6'd9, 1'b1, "R11");

        // R8: flush-all of one database removes static too, others stay
        set_data(16'h0000);
        cmd(3'd5, 6'd5, 1'b0, "R8");
        walk(6'd5, "R8");
        walk(6'd9, "R8");
        // R8: flush-all of every database
        set_data(16'h0000);
        cmd(3'd1, 6'd0, 1'b0, "R8");
        walk(6'd9, "R8");
        walk(6'd37, "R8");

        // R5: fill the table, then a new key is dropped
        for (int i = 1; i <= N; i++)
            load(6'd3, 48'h0000_0000_0100 + 48'(i), mkd(1'b0, 5'(i), 4'h7), "R4");
        load(6'd3, 48'h0000_0000_0900, mkd(1'b0, 5'h01, 4'h7), "R5");
        // R4: overwrite still works when full
        load(6'd3, 48'h0000_0000_0105, mkd(1'b1, 5'h1E, 4'h6), "R4");
        walk(6'd3, "R5");
        set_data(16'h0000);
        cmd(3'd1, 6'd0, 1'b0, "R8");
        walk(6'd3, "R8");

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule